// File: doc/BRIEF.md
# Palette Entry Format Converter

This block loads a colour lookup table. A load begins with a one-cycle `start` pulse while the block is idle. Then the block accepts 32-bit palette words over a valid/ready stream. It converts each word into a 25-bit internal entry (transparency flag plus 8-bit red, green and blue) and writes that entry to an external 256-entry palette RAM through a simple write port. The pixel depth code sets how many words a load takes. A pixel depth that uses no palette finishes the load at once.

The source word layout comes from a 2-bit format selector and a monochrome flag. Both are captured at `start` and held for the whole load. After a load, the block compares the live format selector with the captured one. It raises `fmt_stale` while they differ, so the host knows it must run the load again.

Top module: `pal_loader`

## Requirements
- R1: The depth code on `depth_sel` sets the entry count of a load: code 1 (2 bpp) loads 4 entries, code 2 (4 bpp) loads 16, and code 3 (8 bpp) loads 256.
- R2: Any other depth code (0, 4 to 7) writes nothing. `done` pulses on the cycle after `start`, and `in_ready` stays low.
- R3: `in_ready` is high only while a load is running. Each cycle with `in_valid` and `in_ready` both high writes exactly one entry (`wr_en` high). Write addresses run 0, 1, 2 and so on in acceptance order.
- R4: `done` is a one-cycle pulse in the cycle after the last entry is written. `in_ready` is low in that cycle.
- R5: Format 0 gives red = {w[15:11],000}, green = {w[10:5],00}, blue = {w[4:0],000} and transparency 0. `wr_data` packs transparency in bit 24, red in 23:16, green in 15:8 and blue in 7:0.
- R6: Format 1 uses the same colour fields as format 0, with transparency = w[24].
- R7: Format 2 gives red = {w[23:19],000}, green = {w[15:10],00}, blue = {w[7:3],000} and transparency = w[24].
- R8: Format 3 gives red = w[23:16], green = w[15:8], blue = w[7:0] and transparency = w[24].
- R9: With `mono` high, red, green and blue all equal w[7:0]. Transparency still follows the format rule.
- R10: Format and monochrome are sampled at `start`. Changes to them during a load do not affect the entries written by that load.
- R11: `fmt_stale` is 0 after reset. After any load has started, it is high exactly while `pal_fmt` differs from the format captured at the most recent `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load (honoured only when idle) |
| depth_sel | input | 3 | Pixel depth code |
| pal_fmt | input | 2 | Source word layout selector |
| mono | input | 1 | Monochrome replicate mode |
| in_valid | input | 1 | Palette word valid |
| in_data | input | 32 | Palette word |
| in_ready | output | 1 | Block accepts a word |
| wr_en | output | 1 | Palette RAM write enable |
| wr_addr | output | 8 | Palette RAM write address |
| wr_data | output | 25 | Converted entry {transp, r, g, b} |
| done | output | 1 | Load complete pulse |
| fmt_stale | output | 1 | Live format differs from the last loaded one |

## Verification
The hardest case to reach from the ports is a format change in the middle of a load. The entries must still follow the captured format, and the change must appear only on `fmt_stale` once the load is over. The stimulus flips `pal_fmt` right after the first accepted word of every load. It then checks each remaining entry against the captured format, checks `fmt_stale` after `done`, and checks that `fmt_stale` clears when the selector is restored. The sweep covers every depth code, format and monochrome setting, with both a continuous stream and a stream that has a bubble before every other word.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int TRANSP_BIT = 24;

    typedef struct packed {
        logic       transp;
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } pal_entry_t;

    typedef enum logic [1:0] {
        FMT_565     = 2'd0,
        FMT_565_T   = 2'd1,
        FMT_666_T   = 2'd2,
        FMT_888_T   = 2'd3
    } pal_fmt_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_LOAD = 1'b1
    } ld_state_e;

endpackage

// File: rtl/pal_entry_conv.sv
module pal_entry_conv
    import pal_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] word,
    input  logic [1:0]        fmt,
    input  logic              mono,
    output pal_entry_t        entry
);
    always_comb begin
        entry = '0;
        case (pal_fmt_e'(fmt))
            FMT_565, FMT_565_T: begin
                entry.r = {word[15:11], 3'b000};
                entry.g = {word[10:5],  2'b00};
                entry.b = {word[4:0],   3'b000};
            end
            FMT_666_T: begin
                entry.r = {word[23:19], 3'b000};
                entry.g = {word[15:10], 2'b00};
                entry.b = {word[7:3],   3'b000};
            end
            default: begin
                entry.r = word[23:16];
                entry.g = word[15:8];
                entry.b = word[7:0];
            end
        endcase
        entry.transp = (pal_fmt_e'(fmt) == FMT_565) ? 1'b0 : word[TRANSP_BIT];
        if (mono) begin
            entry.r = word[7:0];
            entry.g = word[7:0];
            entry.b = word[7:0];
        end
    end
endmodule

// File: rtl/pal_load_ctrl.sv
module pal_load_ctrl
    import pal_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DEPTH_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [DEPTH_W-1:0] depth_sel,
    input  logic [1:0]         fmt_in,
    input  logic               mono_in,
    input  logic               in_valid,
    output logic               in_ready,
    output logic [ADDR_W-1:0]  cnt,
    output logic [1:0]         fmt_cap,
    output logic               mono_cap,
    output logic               loaded,
    output logic               done
);
    typedef struct packed {
        ld_state_e         st;
        logic [ADDR_W-1:0] cnt;
        logic [ADDR_W-1:0] lim;
        logic [1:0]        fmt;
        logic              mono;
        logic              loaded;
        logic              done;
    } ctrl_s;

    ctrl_s s_d, s_q;

    // bits per pixel for a depth code is 2**code; palette used only if it fits the RAM
    function automatic logic cfg_valid(input logic [DEPTH_W-1:0] code);
        int bits;
        bits = 1 << int'(code);
        return (code != '0) && (bits <= ADDR_W);
    endfunction

    function automatic logic [ADDR_W-1:0] cfg_last(input logic [DEPTH_W-1:0] code);
        int bits;
        logic [ADDR_W:0] n;
        bits = 1 << int'(code);
        n = '0;
        n[bits] = 1'b1;
        return ADDR_W'(n - 1'b1);
    endfunction

    logic accept;
    assign accept = (s_q.st == ST_LOAD) && in_valid;

    always_comb begin
        s_d = s_q;
        s_d.done = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.fmt    = fmt_in;
                    s_d.mono   = mono_in;
                    s_d.loaded = 1'b1;
                    s_d.cnt    = '0;
                    if (cfg_valid(depth_sel)) begin
                        s_d.st  = ST_LOAD;
                        s_d.lim = cfg_last(depth_sel);
                    end else begin
                        s_d.done = 1'b1;
                    end
                end
            end
            default: begin
                if (accept) begin
                    if (s_q.cnt == s_q.lim) begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready = (s_q.st == ST_LOAD);
    assign cnt      = s_q.cnt;
    assign fmt_cap  = s_q.fmt;
    assign mono_cap = s_q.mono;
    assign loaded   = s_q.loaded;
    assign done     = s_q.done;

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && s_q.cnt != s_q.lim) |=> (in_ready && cnt == $past(cnt) + 1'b1));

    // R4
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && s_q.cnt == s_q.lim) |=> (done && !in_ready));

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready);

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && $past(in_ready)) |-> ($stable(fmt_cap) && $stable(mono_cap)));
endmodule

// File: rtl/pal_loader.sv
module pal_loader
    import pal_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int ADDR_W  = 8,
    parameter int DEPTH_W = 3,
    localparam int ENTRY_W = $bits(pal_entry_t)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [DEPTH_W-1:0] depth_sel,
    input  logic [1:0]         pal_fmt,
    input  logic               mono,
    input  logic               in_valid,
    input  logic [WORD_W-1:0]  in_data,
    output logic               in_ready,
    output logic               wr_en,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [ENTRY_W-1:0] wr_data,
    output logic               done,
    output logic               fmt_stale
);
    logic [1:0] fmt_cap;
    logic       mono_cap;
    logic       loaded;
    pal_entry_t entry;

    pal_load_ctrl #(.ADDR_W(ADDR_W), .DEPTH_W(DEPTH_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .depth_sel(depth_sel),
        .fmt_in   (pal_fmt),
        .mono_in  (mono),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .cnt      (wr_addr),
        .fmt_cap  (fmt_cap),
        .mono_cap (mono_cap),
        .loaded   (loaded),
        .done     (done)
    );

    pal_entry_conv #(.WORD_W(WORD_W)) u_conv (
        .word (in_data),
        .fmt  (fmt_cap),
        .mono (mono_cap),
        .entry(entry)
    );

    assign wr_en     = in_valid && in_ready;
    assign wr_data   = entry;
    assign fmt_stale = loaded && (pal_fmt != fmt_cap);

    // R5
    blue_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mono_cap && fmt_cap != 2'd3) |-> (wr_data[2:0] == 3'b000));

    // R11
    stale_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !in_ready && !$past(!rst_n)) |=> (!fmt_stale || pal_fmt != $past(pal_fmt)));

    // R3
    no_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> !wr_en);
endmodule

// File: tb/pal_loader_test.sv
module pal_loader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  depth_sel = '0;
    logic [1:0]  pal_fmt = '0;
    logic        mono = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready, wr_en, done, fmt_stale;
    logic [7:0]  wr_addr;
    logic [24:0] wr_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;

    pal_loader uut (
        .clk(clk), .rst_n(rst_n), .start(start), .depth_sel(depth_sel),
        .pal_fmt(pal_fmt), .mono(mono), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .fmt_stale(fmt_stale)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [24:0] model(input logic [31:0] w, input logic [1:0] f, input logic m);
        logic [7:0] r, g, b;
        logic t;
        if (f <= 2'd1) begin
            r = w[15:11] * 8; g = w[10:5] * 4; b = w[4:0] * 8;
        end else if (f == 2'd2) begin
            r = (w[23:16] / 8) * 8; g = (w[15:8] / 4) * 4; b = (w[7:0] / 8) * 8;
        end else begin
            r = w[23:16]; g = w[15:8]; b = w[7:0];
        end
        t = (f == 2'd0) ? 1'b0 : w[24];
        if (m) begin r = w[7:0]; g = w[7:0]; b = w[7:0]; end
        return {t, r, g, b};
    endfunction

    function automatic int entries(input int code);
        if (code == 1) return 4;
        if (code == 2) return 16;
        if (code == 3) return 256;
        return 0;
    endfunction

    task automatic run_load(input int code, input logic [1:0] f, input logic m, input bit gap);
        int n;
        logic [24:0] exp;
        n = entries(code);
        @(negedge clk);
        depth_sel = 3'(code); pal_fmt = f; mono = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (n == 0) begin
            #1;
            check("R2 done", 32'(done), 1);
            check("R2 ready", 32'(in_ready), 0);
            @(negedge clk);
            check("R2 pulse", 32'(done), 0);
            return;
        end
        for (int i = 0; i < n; i++) begin
            if (gap && (i % 2 == 1)) begin
                in_valid = 1'b0;
                #1;
                check("R3 no write in bubble", 32'(wr_en), 0);
                @(negedge clk);
            end
            seed = seed * 32'd1103515245 + 32'd12345;
            in_data = {seed[15:0], seed[31:16]} ^ seed;
            in_valid = 1'b1;
            #1;
            exp = model(in_data, f, m);
            check("R3 ready", 32'(in_ready), 1);
            check("R3 wr_en", 32'(wr_en), 1);
            check("R3 addr", 32'(wr_addr), 32'(i));
            if (m) check("R9 mono", 32'(wr_data), 32'(exp));
            else if (f == 2'd0) check("R5 fmt0", 32'(wr_data), 32'(exp));
            else if (f == 2'd1) check("R6 fmt1", 32'(wr_data), 32'(exp));
            else if (f == 2'd2) check("R7 fmt2", 32'(wr_data), 32'(exp));
            else check("R8 fmt3", 32'(wr_data), 32'(exp));
            check("R4 no early done", 32'(done), 0);
            @(negedge clk);
            if (i == 0) begin
                pal_fmt = f ^ 2'd1;
                mono = ~m;
            end
        end
        in_valid = 1'b0;
        #1;
        check("R4 done", 32'(done), 1);
        check("R4 ready low", 32'(in_ready), 0);
        check("R1 count", 32'(n), 32'(entries(code)));
        check("R11 stale set", 32'(fmt_stale), 1);
        @(negedge clk);
        check("R4 pulse", 32'(done), 0);
        pal_fmt = f;
        #1;
        check("R11 stale clear", 32'(fmt_stale), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R3 reset ready", 32'(in_ready), 0);
        check("R4 reset done", 32'(done), 0);
        check("R11 reset stale", 32'(fmt_stale), 0);
        pal_fmt = 2'd2;
        #1;
        check("R11 stale before load", 32'(fmt_stale), 0);
        for (int code = 0; code < 8; code++)
            for (int f = 0; f < 4; f++)
                for (int m = 0; m < 2; m++)
                    run_load(code, 2'(f), 1'(m), ((code + f + m) % 2) == 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule